// File: doc/BRIEF.md
# Static Not-Taken Branch Squash Controller

This block steers the front of a five-stage pipeline that assumes every branch falls through. Fetch never pauses after a branch: the next in-line addresses keep entering the pipe one per cycle. The external compare logic reports the verdict for the instruction in the memory stage. If the branch goes the fall-through way, the controller does nothing and the branch costs no cycles. If it is taken, or is an unconditional jump, the controller loads the target into the fetch PC. On that same edge it empties the IF/ID, ID/EX and EX/MEM registers, so the three wrong-path instructions become bubbles. Those bubbles cost three cycles.

A small token pipeline carries each fetched address through IF/ID, ID/EX, EX/MEM and MEM/WB with a valid bit. The valid bit qualifies the memory-write and register-write enables, and the MEM/WB register shows which instructions retire. A verdict counts only when the memory stage holds a live instruction. A squashed slot that looks like a branch therefore cannot cause a second redirect.

Top module: `nt_branch_squash`

## Requirements
- R1: While rst_ni is low and after its release, pc_o equals RESET_PC (default 0x100), and mem_valid_o, ret_valid_o, pc_sel_o and all three flush outputs are 0.
- R2: With no redirect, pc_o advances by INSTR_BYTES (default 4) on every clock, with no stall after a branch.
- R3: When br_valid_i is 1 and mem_valid_o is 1, but br_taken_i and br_uncond_i are both 0, pc_sel_o stays 0 (sequential) and no flush output rises. The branch at address A then retires followed by A+4, A+8 and A+12 on consecutive cycles.
- R4: When br_valid_i and mem_valid_o are both 1 and br_taken_i is 1, the following happen in the same cycle: pc_sel_o is 1 (target) and flush_ifid_o, flush_idex_o and flush_exmem_o are all 1. After the next edge, pc_o equals br_target_i and mem_valid_o is 0.
- R5: For a taken branch at A with target P, the retire sequence on ret_pc_o is A, P, P+4, P+8. Exactly three cycles with ret_valid_o at 0 lie between A and P.
- R6: An unconditional branch (br_uncond_i = 1) redirects and flushes exactly as in R4, even when br_taken_i is 0.
- R7: A verdict that arrives while mem_valid_o is 0 is ignored: pc_sel_o stays 0, no flush rises and pc_o advances by INSTR_BYTES.
- R8: While br_valid_i is 0, the values on br_taken_i, br_uncond_i and br_target_i have no effect on pc_o or on the flush outputs.
- R9: mem_we_o is 1 only when mem_wr_req_i is 1 and mem_valid_o is 1. rf_we_o is 1 only when rf_wr_req_i is 1 and ret_valid_o is 1. A squashed instruction therefore never raises either enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Memory-stage instruction is a branch with a verdict |
| br_taken_i | input | 1 | Conditional branch outcome is taken |
| br_uncond_i | input | 1 | Branch is unconditional |
| br_target_i | input | PC_W | Branch target address |
| mem_wr_req_i | input | 1 | Memory-stage instruction wants to store |
| rf_wr_req_i | input | 1 | Writeback-stage instruction wants to write a register |
| pc_o | output | PC_W | Current fetch address |
| pc_sel_o | output | 1 | Next-PC select: 0 sequential, 1 target |
| flush_ifid_o | output | 1 | Clear IF/ID on this edge |
| flush_idex_o | output | 1 | Clear ID/EX on this edge |
| flush_exmem_o | output | 1 | Clear EX/MEM on this edge |
| mem_valid_o | output | 1 | Memory stage holds a live instruction |
| mem_pc_o | output | PC_W | Address of the memory-stage instruction |
| mem_we_o | output | 1 | Gated memory write enable |
| rf_we_o | output | 1 | Gated register-file write enable |
| ret_valid_o | output | 1 | An instruction retires this cycle |
| ret_pc_o | output | PC_W | Address of the retiring instruction |

## Verification
The bench probes a branch at the very first fetched address, jumps both forward and backward, and an unconditional jump whose taken flag is low. A design that checked only the taken flag would let that jump fall through and retire A+4. A verdict raised while the memory slot is a bubble must be dropped; a controller that skipped the valid qualifier would redirect on a ghost branch and skip instructions. The bench also counts the idle retire cycles between a taken branch and its target, which exposes a flush that clears too few or too many registers. It watches both write enables for wrong-path addresses, and leaking gating shows there as a store or register write by B, C or D.

// File: rtl/nt_branch_squash_pkg.sv
package nt_branch_squash_pkg;
  typedef enum logic {
    SEL_SEQ = 1'b0,
    SEL_TGT = 1'b1
  } pc_sel_e;

  localparam int STG_IFID  = 0;
  localparam int STG_IDEX  = 1;
  localparam int STG_EXMEM = 2;
  localparam int STG_MEMWB = 3;
  localparam int N_STG     = 4;
  // registers younger than the resolving slot, cleared on redirect
  localparam int N_FLUSH   = STG_EXMEM + 1;
endpackage

// File: rtl/nbs_fetch.sv
module nbs_fetch #(
  parameter int          PC_W        = 32,
  parameter logic [31:0] RESET_PC    = 32'h100,
  parameter int          INSTR_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);
  localparam logic [PC_W-1:0] PC0  = RESET_PC[PC_W-1:0];

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb pc_d = redirect_i ? target_i : pc_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/nbs_stage.sv
module nbs_stage #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            vld_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            vld_o,
  output logic [PC_W-1:0] pc_o
);
  logic            vld_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      vld_q <= vld_i;
      pc_q  <= pc_i;
    end
  end

  assign vld_o = vld_q;
  assign pc_o  = pc_q;
endmodule

// File: rtl/nbs_resolve.sv
module nbs_resolve
  import nt_branch_squash_pkg::*;
(
  input  logic             br_valid_i,
  input  logic             br_taken_i,
  input  logic             br_uncond_i,
  input  logic             slot_live_i,
  output logic             redirect_o,
  output pc_sel_e          sel_o,
  output logic [N_STG-1:0] clr_o
);
  logic hit;

  // verdict only counts for a live instruction in the resolving slot
  always_comb begin
    hit        = br_valid_i & slot_live_i;
    redirect_o = hit & (br_taken_i | br_uncond_i);
    sel_o      = redirect_o ? SEL_TGT : SEL_SEQ;
  end

  for (genvar k = 0; k < N_STG; k++) begin : g_clr
    if (k < N_FLUSH) begin : g_young
      assign clr_o[k] = redirect_o;
    end else begin : g_old
      assign clr_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/nbs_wgate.sv
module nbs_wgate (
  input  logic mem_req_i,
  input  logic mem_live_i,
  input  logic rf_req_i,
  input  logic wb_live_i,
  output logic mem_we_o,
  output logic rf_we_o
);
  assign mem_we_o = mem_req_i & mem_live_i;
  assign rf_we_o  = rf_req_i & wb_live_i;
endmodule

// File: rtl/nt_branch_squash.sv
module nt_branch_squash
  import nt_branch_squash_pkg::*;
#(
  parameter int          PC_W        = 32,
  parameter logic [31:0] RESET_PC    = 32'h100,
  parameter int          INSTR_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            br_valid_i,
  input  logic            br_taken_i,
  input  logic            br_uncond_i,
  input  logic [PC_W-1:0] br_target_i,
  input  logic            mem_wr_req_i,
  input  logic            rf_wr_req_i,
  output logic [PC_W-1:0] pc_o,
  output logic            pc_sel_o,
  output logic            flush_ifid_o,
  output logic            flush_idex_o,
  output logic            flush_exmem_o,
  output logic            mem_valid_o,
  output logic [PC_W-1:0] mem_pc_o,
  output logic            mem_we_o,
  output logic            rf_we_o,
  output logic            ret_valid_o,
  output logic [PC_W-1:0] ret_pc_o
);
  logic             redirect;
  pc_sel_e          sel;
  logic [N_STG-1:0] clr;
  logic [PC_W-1:0]  fetch_pc;
  logic [N_STG:0]   vld;
  logic [PC_W-1:0]  spc [N_STG+1];

  nbs_fetch #(
    .PC_W(PC_W), .RESET_PC(RESET_PC), .INSTR_BYTES(INSTR_BYTES)
  ) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .redirect_i(redirect), .target_i(br_target_i), .pc_o(fetch_pc)
  );

  // slot 0 is the fetch stage, always live out of reset
  assign vld[0] = 1'b1;
  assign spc[0] = fetch_pc;

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    nbs_stage #(.PC_W(PC_W)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr[s]),
      .vld_i(vld[s]), .pc_i(spc[s]),
      .vld_o(vld[s+1]), .pc_o(spc[s+1])
    );
  end

  nbs_resolve u_resolve (
    .br_valid_i(br_valid_i), .br_taken_i(br_taken_i), .br_uncond_i(br_uncond_i),
    .slot_live_i(vld[STG_EXMEM+1]),
    .redirect_o(redirect), .sel_o(sel), .clr_o(clr)
  );

  nbs_wgate u_wgate (
    .mem_req_i(mem_wr_req_i), .mem_live_i(vld[STG_EXMEM+1]),
    .rf_req_i(rf_wr_req_i),   .wb_live_i(vld[STG_MEMWB+1]),
    .mem_we_o(mem_we_o), .rf_we_o(rf_we_o)
  );

  assign pc_o          = fetch_pc;
  assign pc_sel_o      = sel;
  assign flush_ifid_o  = clr[STG_IFID];
  assign flush_idex_o  = clr[STG_IDEX];
  assign flush_exmem_o = clr[STG_EXMEM];
  assign mem_valid_o   = vld[STG_EXMEM+1];
  assign mem_pc_o      = spc[STG_EXMEM+1];
  assign ret_valid_o   = vld[STG_MEMWB+1];
  assign ret_pc_o      = spc[STG_MEMWB+1];
endmodule

// File: rtl/nt_branch_squash_chk.sv
module nt_branch_squash_chk #(
  parameter int          PC_W        = 32,
  parameter logic [31:0] RESET_PC    = 32'h100,
  parameter int          INSTR_BYTES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            br_valid_i,
  input logic            br_taken_i,
  input logic            br_uncond_i,
  input logic [PC_W-1:0] br_target_i,
  input logic            mem_wr_req_i,
  input logic            rf_wr_req_i,
  input logic [PC_W-1:0] pc_o,
  input logic            pc_sel_o,
  input logic            flush_ifid_o,
  input logic            flush_idex_o,
  input logic            flush_exmem_o,
  input logic            mem_valid_o,
  input logic            mem_we_o,
  input logic            rf_we_o,
  input logic            ret_valid_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);
  logic go;
  assign go = br_valid_i & mem_valid_o & (br_taken_i | br_uncond_i);

  // R4
  redirect_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (pc_o == $past(br_target_i)) && !mem_valid_o);

  // R4
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |-> flush_ifid_o && flush_idex_o && flush_exmem_o);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_sel_o |=> pc_o == $past(pc_o) + STEP);

  // R7
  ghost_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_valid_o |-> !flush_exmem_o && !pc_sel_o);

  // R5
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> ##1 !ret_valid_o);

  // R9
  mem_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_valid_o && mem_wr_req_i);

  // R9
  rf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ret_valid_o && rf_wr_req_i);
endmodule

bind nt_branch_squash nt_branch_squash_chk #(
  .PC_W(PC_W), .RESET_PC(RESET_PC), .INSTR_BYTES(INSTR_BYTES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .br_valid_i(br_valid_i), .br_taken_i(br_taken_i),
  .br_uncond_i(br_uncond_i), .br_target_i(br_target_i), .mem_wr_req_i(mem_wr_req_i),
  .rf_wr_req_i(rf_wr_req_i), .pc_o(pc_o), .pc_sel_o(pc_sel_o),
  .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
  .flush_exmem_o(flush_exmem_o), .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
  .rf_we_o(rf_we_o), .ret_valid_o(ret_valid_o)
);

// File: tb/nt_branch_squash_test.sv
module nt_branch_squash_test;
  localparam int          PC_W = 32;
  localparam logic [31:0] RPC  = 32'h100;

  typedef struct packed {
    logic [31:0] br_pc;
    logic        taken;
    logic        uncond;
    logic [31:0] tgt;
    logic [1:0]  exp_bub;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h108, 1'b1, 1'b0, 32'h200, 2'd3},  // R4 R5 forward taken
    '{32'h108, 1'b0, 1'b0, 32'h300, 2'd0},  // R3 fall-through
    '{32'h110, 1'b0, 1'b1, 32'h400, 2'd3},  // R6 unconditional, taken low
    '{32'h100, 1'b1, 1'b0, 32'h180, 2'd3},  // R5 branch is first fetch
    '{32'h114, 1'b0, 1'b0, 32'h500, 2'd0},  // R3
    '{32'h10c, 1'b1, 1'b1, 32'h0f0, 2'd3}   // R5 backward target
  };

  logic clk = 0, rst_ni = 0;
  logic br_valid_i = 0, br_taken_i = 0, br_uncond_i = 0;
  logic [PC_W-1:0] br_target_i = '0;
  logic mem_wr_req_i = 1, rf_wr_req_i = 1;
  logic [PC_W-1:0] pc_o, mem_pc_o, ret_pc_o;
  logic pc_sel_o, flush_ifid_o, flush_idex_o, flush_exmem_o;
  logic mem_valid_o, mem_we_o, rf_we_o, ret_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nt_branch_squash #(.PC_W(PC_W), .RESET_PC(RPC), .INSTR_BYTES(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .br_valid_i(br_valid_i), .br_taken_i(br_taken_i),
    .br_uncond_i(br_uncond_i), .br_target_i(br_target_i), .mem_wr_req_i(mem_wr_req_i),
    .rf_wr_req_i(rf_wr_req_i), .pc_o(pc_o), .pc_sel_o(pc_sel_o),
    .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
    .flush_exmem_o(flush_exmem_o), .mem_valid_o(mem_valid_o), .mem_pc_o(mem_pc_o),
    .mem_we_o(mem_we_o), .rf_we_o(rf_we_o), .ret_valid_o(ret_valid_o),
    .ret_pc_o(ret_pc_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; br_valid_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    rst_ni = 0;
    repeat (2) @(negedge clk);
    check(pc_o == RPC, "R1 pc", pc_o, RPC);
    check({mem_valid_o, ret_valid_o, pc_sel_o, flush_ifid_o, flush_idex_o,
           flush_exmem_o} == 6'b0, "R1 state", {26'd0, mem_valid_o, ret_valid_o,
           pc_sel_o, flush_ifid_o, flush_idex_o, flush_exmem_o}, 32'd0);

    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic bit jmp = v.taken | v.uncond;
      automatic bit fired = 0, chk_pc = 0, started = 0;
      automatic int nret = 0, bub = 0, viol = 0;
      automatic logic [31:0] seq [4];
      do_reset();
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (chk_pc) begin
          check(pc_o == v.tgt, "R4 redirect pc", pc_o, v.tgt);
          chk_pc = 0;
        end
        // br_valid_i low with taken high must be harmless (R8)
        br_valid_i = 0; br_taken_i = 1; br_uncond_i = 1; br_target_i = 32'hdead0;
        if (!fired && mem_valid_o && mem_pc_o == v.br_pc) begin
          br_valid_i = 1; br_taken_i = v.taken; br_uncond_i = v.uncond;
          br_target_i = v.tgt;
        end
        #1;
        if (br_valid_i) begin
          fired = 1;
          chk_pc = jmp;
          check({pc_sel_o, flush_ifid_o, flush_idex_o, flush_exmem_o} == {4{jmp}},
                jmp ? (v.uncond ? "R6 flush" : "R4 flush") : "R3 no flush",
                {28'd0, pc_sel_o, flush_ifid_o, flush_idex_o, flush_exmem_o},
                {28'd0, {4{jmp}}});
        end else if (!fired) begin
          check(!pc_sel_o && !flush_exmem_o, "R8 idle verdict",
                {31'd0, pc_sel_o}, 32'd0);
        end
        if (jmp && fired && nret < 4) begin
          for (int k = 1; k <= 3; k++) begin
            if (mem_we_o && mem_pc_o == v.br_pc + 32'(4*k)) viol++;
            if (rf_we_o && ret_pc_o == v.br_pc + 32'(4*k)) viol++;
          end
        end
        if (ret_valid_o) begin
          if (!started && ret_pc_o == v.br_pc) started = 1;
          if (started && nret < 4) begin
            seq[nret] = ret_pc_o;
            nret++;
          end
        end else if (started && nret == 1) begin
          bub++;
        end
      end
      check(nret == 4, "R5 retire count", nret, 4);
      for (int k = 0; k < 4; k++) begin
        automatic logic [31:0] e = (k == 0) ? v.br_pc :
          (jmp ? v.tgt + 32'(4*(k-1)) : v.br_pc + 32'(4*k));
        check(seq[k] == e, jmp ? "R5 retire order" : "R3 retire order", seq[k], e);
      end
      check(bub == int'(v.exp_bub), jmp ? "R5 bubbles" : "R3 bubbles", bub, v.exp_bub);
      check(viol == 0, "R9 squashed write", viol, 0);
    end

    // R2 sequential fetch, R7 ghost verdict, R9 gating on empty slot
    do_reset();
    begin
      automatic logic [31:0] prev;
      br_valid_i = 1; br_taken_i = 1; br_uncond_i = 0; br_target_i = 32'h800;
      #1;
      check(!mem_valid_o && !pc_sel_o && !flush_ifid_o, "R7 ghost ignored",
            {31'd0, pc_sel_o}, 32'd0);
      check(!mem_we_o, "R9 mem gate", {31'd0, mem_we_o}, 32'd0);
      prev = pc_o;
      @(negedge clk);
      check(pc_o == prev + 4, "R7 pc advance", pc_o, prev + 4);
      br_valid_i = 0;
      for (int c = 0; c < 4; c++) begin
        prev = pc_o;
        @(negedge clk);
        check(pc_o == prev + 4, "R2 step", pc_o, prev + 4);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule